// File: doc/BRIEF.md
# Compressed Code Fetch Controller

This block sits between a processor's instruction-fetch port and a memory port. A static address window marks compressed code. Fetches that fall outside the window are steered straight to memory, and the memory's answer is steered straight back, with no register on the way. Fetches inside the window are answered from a 64-byte line buffer that holds one expanded block.

When an in-window fetch misses the line, the controller works out which 128-byte group and which 64-byte half the target belongs to. It reads that group's index word unless the group's word is already held. It then streams the block's stored bytes from memory and expands them into the line, starting at byte 0. The expansion is either a byte-level run-length decode or, for blocks flagged raw, a plain copy. The fetch is answered as soon as its four bytes exist. The fill then carries on to the end of the line, so the rest of the block is already buffered when the processor asks for it.

Both ports use a held-request handshake. The requester raises `req` with a stable address and keeps both until `rvalid` is high for one cycle, and it may drop or change them after that clock edge.

Top module: `ccf_ctrl`

## Requirements
- R1: A fetch whose address lies outside [win_base, win_base+win_size), made while no fill is running, drives mem_req and mem_addr equal to cpu_req and cpu_addr in the same cycle. cpu_rvalid and cpu_rdata equal mem_rvalid and mem_rdata in the same cycle, so the latency is exactly the memory's.
- R2: The line holds one 64-byte block. After a completed fill, a read at window offset o returns the bytes o&~3 through (o&~3)+3 of the expanded block, little-endian (lowest offset in bits 7:0).
- R3: After a miss, the fill continues until all 64 bytes are present, even once the requested word has been returned and no further fetch arrives.
- R4: A fetch that finds its block in the line with its four bytes present is answered in the same cycle it is presented (zero cycles), which is faster than any memory access.
- R5: The index word for group g = (addr-win_base)>>7 is read from idx_base+4*g. Its fields are: bits 21:0, the group's stored start address (word aligned); bits 29:22, the stored length L of the lower block; bit 30, the raw flag of the lower block; bit 31, the raw flag of the upper block. The upper block starts at start+((L+3)&~3). A block whose raw flag is 1 is copied byte for byte into the line without decoding.
- R6: A block whose raw flag is 0 is run-length coded. A control byte c with bit 7 set repeats the following byte (c&127)+1 times. With bit 7 clear, it copies the next (c&127)+1 bytes as literals.
- R7: The line is always filled from byte 0 of the block, so a miss aimed at a later word of a block takes longer than a miss aimed at its first word under the same conditions.
- R8: A miss in the group whose index word is held reads no index word. A miss in any other group reads exactly one.
- R9: A fetch that arrives while a fill is running is held. A fetch to the block being filled is answered once its bytes exist. Any other fetch, in-window or not, is answered only after the fill ends. Every answer carries correct data.
- R10: After reset, cpu_rvalid and mem_req are low while no fetch is presented. The first in-window fetch reads one index word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | AW | Start address of the compressed window (static) |
| win_size | input | AW | Size of the compressed window in bytes (static) |
| idx_base | input | AW | Address of the index table (static) |
| cpu_req | input | 1 | Fetch request, held until answered |
| cpu_addr | input | AW | Fetch byte address |
| cpu_rvalid | output | 1 | Fetch answered this cycle |
| cpu_rdata | output | 32 | Fetch data |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory answer valid this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench fills the window with blocks of four kinds, and each kind exercises a different part of the decoder or the copy path. The first kind is repeated runs. The second is a raw copy. The third is a long run followed by literals. The fourth is one 64-byte literal run. Every word of all sixteen blocks is read once a miss has been made at a varied offset. A mismatch therefore shows a decoder miscount, a wrong upper-block address or a wrong byte order. Plain memory addresses check the zero-cycle pass path. Sequences of fetches at the first and last word of a block, within one group and across groups, and fetches issued during a fill separate start-of-block decoding, index reuse and request holding.

// File: rtl/ccf_ctrl.sv
module ccf_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] win_size,
  input  logic [AW-1:0] idx_base,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_rvalid,
  output logic [31:0]   cpu_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  localparam int LINE = 64;
  localparam int OW   = $clog2(LINE);
  localparam int BW   = AW - OW;
  localparam int GW   = BW - 1;

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_DATA, S_DEC, S_SERVE} st_t;
  typedef enum logic [1:0] {D_CTRL, D_LIT, D_RUNB, D_RUN} dm_t;

  st_t            st;
  dm_t            dm;
  logic [BW-1:0]  blk_tag;
  logic           tag_ok;
  logic [GW-1:0]  idx_grp;
  logic           idx_ok;
  logic [31:0]    idx_ent;
  logic [AW-1:0]  src;
  logic [31:0]    wbuf;
  logic           raw;
  logic [6:0]     cnt;
  logic [7:0]     runv;
  logic [7:0]     obuf [LINE];
  logic [LINE-1:0] bval;
  logic [OW-1:0]  fptr;

  function automatic logic [AW-1:0] blk_start(input logic [31:0] e, input logic hi);
    logic [9:0] rl;
    rl = ({2'b00, e[29:22]} + 10'd3) & ~10'd3;
    return AW'(e[21:0]) + (hi ? AW'(rl) : '0);
  endfunction

  function automatic logic raw_flag(input logic [31:0] e, input logic hi);
    return hi ? e[31] : e[30];
  endfunction

  logic [AW-1:0] off;
  logic          in_win, idle_ok, pass, line_hit, miss;
  logic [3:0]    wsel;
  logic [7:0]    cur, ebyte;
  logic          consume, emit, last;

  assign off     = cpu_addr - win_base;
  assign in_win  = off < win_size;
  assign idle_ok = (st == S_IDLE) || (st == S_SERVE);
  assign pass    = idle_ok && !in_win;
  assign wsel    = off[OW-1:2];
  assign line_hit = cpu_req && in_win && tag_ok && (blk_tag == off[AW-1:OW])
                    && (&bval[{wsel, 2'b00} +: 4]);
  assign miss    = cpu_req && in_win && idle_ok && !line_hit;

  assign mem_req  = pass ? cpu_req : ((st == S_IDX) || (st == S_DATA));
  assign mem_addr = pass ? cpu_addr :
                    (st == S_IDX) ? idx_base + (AW'(blk_tag >> 1) << 2) :
                    {src[AW-1:2], 2'b00};

  assign cpu_rvalid = pass ? mem_rvalid : line_hit;
  assign cpu_rdata  = pass ? mem_rdata :
                      {obuf[{wsel, 2'd3}], obuf[{wsel, 2'd2}], obuf[{wsel, 2'd1}], obuf[{wsel, 2'd0}]};

  assign cur     = wbuf[8*src[1:0] +: 8];
  assign consume = raw || (dm != D_RUN);
  assign emit    = raw || (dm != D_CTRL);
  assign ebyte   = (!raw && dm == D_RUN) ? runv : cur;
  assign last    = emit && (&fptr);

  always_ff @(posedge clk) begin
    if (st == S_DEC && emit) obuf[fptr] <= ebyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dm      <= D_CTRL;
      blk_tag <= '0;
      tag_ok  <= 1'b0;
      idx_grp <= '0;
      idx_ok  <= 1'b0;
      idx_ent <= '0;
      src     <= '0;
      wbuf    <= '0;
      raw     <= 1'b0;
      cnt     <= '0;
      runv    <= '0;
      bval    <= '0;
      fptr    <= '0;
    end else begin
      case (st)
        S_IDLE, S_SERVE: begin
          if (miss) begin
            blk_tag <= off[AW-1:OW];
            tag_ok  <= 1'b1;
            bval    <= '0;
            fptr    <= '0;
            dm      <= D_CTRL;
            if (idx_ok && idx_grp == off[AW-1:OW+1]) begin
              src <= blk_start(idx_ent, off[OW]);
              raw <= raw_flag(idx_ent, off[OW]);
              st  <= S_DATA;
            end else begin
              st  <= S_IDX;
            end
          end
        end
        S_IDX: begin
          if (mem_rvalid) begin
            idx_ent <= mem_rdata;
            idx_grp <= blk_tag[BW-1:1];
            idx_ok  <= 1'b1;
            src     <= blk_start(mem_rdata, blk_tag[0]);
            raw     <= raw_flag(mem_rdata, blk_tag[0]);
            st      <= S_DATA;
          end
        end
        S_DATA: begin
          if (mem_rvalid) begin
            wbuf <= mem_rdata;
            st   <= S_DEC;
          end
        end
        S_DEC: begin
          if (emit) begin
            bval[fptr] <= 1'b1;
            fptr       <= fptr + 1'b1;
          end
          if (consume) src <= src + 1'b1;
          if (!raw) begin
            case (dm)
              D_CTRL: begin
                cnt <= cur[6:0];
                dm  <= cur[7] ? D_RUNB : D_LIT;
              end
              D_LIT: begin
                if (cnt == 7'd0) dm <= D_CTRL;
                else cnt <= cnt - 1'b1;
              end
              D_RUNB: begin
                runv <= cur;
                if (cnt == 7'd0) dm <= D_CTRL;
                else begin
                  dm  <= D_RUN;
                  cnt <= cnt - 1'b1;
                end
              end
              default: begin
                if (cnt == 7'd0) dm <= D_CTRL;
                else cnt <= cnt - 1'b1;
              end
            endcase
          end
          if (last) st <= S_SERVE;
          else if (consume && src[1:0] == 2'd3) st <= S_DATA;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccf_ctrl_chk.sv
module ccf_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rvalid,
  input logic [31:0]   cpu_rdata,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic [31:0]   mem_rdata,
  input logic          in_win,
  input logic [2:0]    st,
  input logic [63:0]   bval
);
  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !in_win && (st == 3'd0 || st == 3'd4)) |->
      (mem_req && mem_addr == cpu_addr && cpu_rvalid == mem_rvalid && cpu_rdata == mem_rdata));

  a_r7_prefix_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bval & (bval + 64'd1)) == 64'd0);

  a_r3_no_lost_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) == 3'd3) |-> (($past(bval) & ~bval) == 64'd0));

  a_r3_serve_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4) |-> (&bval));

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && (st == 3'd1 || st == 3'd2)) |=> (mem_req && $stable(mem_addr)));

  a_r4_answer_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && in_win) |-> cpu_req);
endmodule

bind ccf_ctrl ccf_ctrl_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .in_win(in_win), .st(st), .bval(bval)
);

// File: tb/ccf_ctrl_tb.sv
module ccf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int LAT   = 3;
  localparam logic [15:0] WBASE = 16'h0800;
  localparam logic [15:0] WSIZE = 16'h0400;
  localparam logic [15:0] IBASE = 16'h0100;
  localparam int CBASE = 16'h0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid;
  logic [31:0] mem_rdata;

  logic [7:0] mb [4096];
  int checks = 0;
  int fails = 0;
  int idx_cnt = 0;
  int mcnt = 0;
  int wp;
  logic f_mreq;
  logic [AW-1:0] f_maddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccf_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .win_base(WBASE), .win_size(WSIZE), .idx_base(IBASE),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rdw(input logic [15:0] a);
    return {mb[{a[11:2], 2'd3}], mb[{a[11:2], 2'd2}], mb[{a[11:2], 2'd1}], mb[{a[11:2], 2'd0}]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      mcnt       <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      mcnt       <= 0;
    end else if (mem_req) begin
      if (mcnt == LAT - 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rdw(mem_addr);
        mcnt       <= 0;
        if (mem_addr >= IBASE && mem_addr < IBASE + 16'd32) idx_cnt <= idx_cnt + 1;
      end else begin
        mcnt <= mcnt + 1;
      end
    end else begin
      mcnt <= 0;
    end
  end

  function automatic int typ(input int b);
    return (b + b / 4) % 4;
  endfunction

  function automatic logic [7:0] pbyte(input int b, input int i);
    case (typ(b))
      0:       return 8'((i / 8) * 3 + b);
      1:       return 8'(i * 7 + b * 13);
      2:       return (i < 32) ? (8'hA5 ^ 8'(b)) : 8'(i * 3 + b);
      default: return 8'(i * 11 + b);
    endcase
  endfunction

  function automatic logic [31:0] expw(input logic [15:0] a);
    int off, b, i;
    if (a >= WBASE && a < WBASE + WSIZE) begin
      off = int'(a - WBASE);
      b = off / 64;
      i = (off % 64) & ~3;
      return {pbyte(b, i + 3), pbyte(b, i + 2), pbyte(b, i + 1), pbyte(b, i)};
    end
    return rdw(a);
  endfunction

  task automatic put(input logic [7:0] v);
    mb[wp] = v;
    wp++;
  endtask

  task automatic enc(input int b);
    case (typ(b))
      0: for (int r = 0; r < 8; r++) begin put(8'h87); put(pbyte(b, r * 8)); end
      1: for (int i = 0; i < 64; i++) put(pbyte(b, i));
      2: begin
        put(8'h9F); put(pbyte(b, 0)); put(8'h1F);
        for (int i = 32; i < 64; i++) put(pbyte(b, i));
      end
      default: begin
        put(8'h3F);
        for (int i = 0; i < 64; i++) put(pbyte(b, i));
      end
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    cpu_addr = a;
    cpu_req = 1'b1;
    lat = 0;
    #1;
    f_mreq = mem_req;
    f_maddr = mem_addr;
    while (!cpu_rvalid) begin
      @(negedge clk);
      lat++;
      #1;
    end
    d = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] d, ent;
    int lat, l0, l15, base, len0, ic;
    logic [15:0] a;

    for (int i = 0; i < 4096; i++) mb[i] = 8'(i * 37) ^ 8'(i >> 8);
    wp = CBASE;
    for (int g = 0; g < 8; g++) begin
      base = wp;
      enc(2 * g);
      len0 = wp - base;
      wp = (wp + 3) & ~3;
      enc(2 * g + 1);
      wp = (wp + 3) & ~3;
      ent = {typ(2 * g + 1) == 1, typ(2 * g) == 1, 8'(len0), 22'(base)};
      for (int k = 0; k < 4; k++) mb[int'(IBASE) + 4 * g + k] = ent[8 * k +: 8];
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cpu_rvalid == 1'b0, "R10 rvalid after reset", 32'(cpu_rvalid), 0);
    chk(mem_req == 1'b0, "R10 mem_req after reset", 32'(mem_req), 0);

    ic = idx_cnt;
    rd(WBASE, d, lat);
    chk(d == expw(WBASE), "R10 first read data", d, expw(WBASE));
    chk(idx_cnt - ic == 1, "R10 first read index fetches", 32'(idx_cnt - ic), 1);
    settle();

    for (int k = 0; k < 8; k++) begin
      a = (k < 4) ? 16'(k * 4) : 16'(16'h0C00 + k * 36);
      rd(a, d, lat);
      chk(d == rdw(a), "R1 pass data", d, rdw(a));
      chk(lat == LAT, "R1 pass latency", 32'(lat), LAT);
      chk(f_mreq && f_maddr == a, "R1 pass address", 32'(f_maddr), 32'(a));
    end

    for (int b = 0; b < 16; b++) begin
      settle();
      a = WBASE + 16'(b * 64 + ((b * 5) % 16) * 4);
      rd(a, d, lat);
      chk(d == expw(a), (typ(b) == 1) ? "R5 raw block miss data" : "R6 decoded block miss data", d, expw(a));
      settle();
      for (int w = 0; w < 16; w++) begin
        a = WBASE + 16'(b * 64 + w * 4);
        rd(a, d, lat);
        chk(d == expw(a), "R2 line word data", d, expw(a));
        chk(lat == 0, "R3 R4 filled line hit latency", 32'(lat), 0);
      end
    end

    for (int p = 2; p < 4; p++) begin
      settle(); rd(WBASE + 16'((2 * p + 1) * 64), d, lat);
      settle(); rd(WBASE + 16'(2 * p * 64), d, l0);
      settle(); rd(WBASE + 16'((2 * p + 1) * 64), d, lat);
      settle(); rd(WBASE + 16'(2 * p * 64 + 60), d, l15);
      chk(d == expw(WBASE + 16'(2 * p * 64 + 60)), "R7 last word data", d, expw(WBASE + 16'(2 * p * 64 + 60)));
      chk(l15 > l0, "R7 later word slower", 32'(l15), 32'(l0));
    end

    settle(); ic = idx_cnt; rd(WBASE + 16'(8 * 64), d, lat);
    chk(idx_cnt - ic == 1, "R8 new group index read", 32'(idx_cnt - ic), 1);
    settle(); ic = idx_cnt; rd(WBASE + 16'(9 * 64 + 12), d, lat);
    chk(idx_cnt - ic == 0, "R8 same group index reuse", 32'(idx_cnt - ic), 0);
    chk(d == expw(WBASE + 16'(9 * 64 + 12)), "R8 same group data", d, expw(WBASE + 16'(9 * 64 + 12)));
    settle(); ic = idx_cnt; rd(WBASE + 16'(10 * 64), d, lat);
    chk(idx_cnt - ic == 1, "R8 other group index read", 32'(idx_cnt - ic), 1);

    settle();
    rd(WBASE + 16'(12 * 64), d, lat);
    rd(WBASE + 16'(12 * 64 + 32), d, lat);
    chk(d == expw(WBASE + 16'(12 * 64 + 32)), "R9 same block during fill", d, expw(WBASE + 16'(12 * 64 + 32)));
    rd(WBASE + 16'(14 * 64 + 4), d, lat);
    chk(d == expw(WBASE + 16'(14 * 64 + 4)), "R9 other block during fill", d, expw(WBASE + 16'(14 * 64 + 4)));
    rd(16'h0C40, d, lat);
    chk(d == rdw(16'h0C40), "R9 pass during fill data", d, rdw(16'h0C40));
    chk(lat > LAT, "R9 pass waits for fill", 32'(lat), LAT + 1);

    settle();
    report();
  end
endmodule